// File: doc/BRIEF.md
# Movable Composite Shape Renderer

This block paints one movable object onto a 640x480 raster, one pixel at a time. The object is a filled yellow disc laid over a filled blue rectangle. A raster scanner outside the block supplies the current pixel column and row and a flag that says whether that pixel is visible. The block answers with a 12-bit RGB value, one clock later. Membership of each shape is decided by arithmetic against a registered anchor point, which is the top-left corner of the rectangle. The disc test compares a squared distance with the squared radius.

Five single-cycle pulses, already debounced, steer the object: up, down, left, right and home. A pulse is held until the end-of-frame strobe, and the anchor moves only on that strobe, so one frame never shows the object in two places. Each move is clamped so that every pixel of the object stays on screen. Each home pulse also adds one to a four-digit decimal tally that an external digit display shows.

Top module: `shape_renderer`

## Requirements
- R1: After reset the anchor is (280,200), the tally reads 0000 and the colour output is 12'h000.
- R2: On the clock edge that samples `frame_end` high, each pending move is applied. Up moves `anchor_y` by -4, down by +4, left moves `anchor_x` by -4 and right by +4. A pulse that arrives in the same cycle as the strobe counts as pending.
- R3: While `frame_end` is low the anchor does not change. Pulses in one direction during a frame give a single step however many there are. Opposite pulses in the same frame cancel each other.
- R4: The anchor is clamped after each update so that 10 <= `anchor_x` <= 560 and 15 <= `anchor_y` <= 414. These limits keep the whole object inside columns 0..639 and rows 0..479.
- R5: A home pulse pending at the strobe puts the anchor back to (280,200), whatever other moves are also pending.
- R6: Each home pulse adds one to `reset_count` on the next clock edge. The count is held as four BCD digits, with the ones digit in bits [3:0] and the thousands digit in bits [15:12].
- R7: The tally wraps from 9999 to 0000. Only the global reset clears it; a home pulse never clears it.
- R8: Let (ax,ay) be the anchor. A pixel (x,y) with (x-(ax+30))^2 + (y-(ay+25))^2 <= 1600 is yellow, 12'hFFF0 truncated to 12 bits: 12'hFF0. The boundary counts as inside.
- R9: A pixel with ax <= x <= ax+79 and ay <= y <= ay+49 that is not in the disc is blue, 12'h00F. Where the two shapes overlap, yellow wins.
- R10: `rgb` is registered and shows the pixel sampled at the previous clock edge. It is 12'h000 outside both shapes, and also whenever `vid_on` was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| vid_on | input | 1 | High when the current pixel is in the visible area |
| frame_end | input | 1 | One-cycle strobe at the end of each frame |
| btn_up | input | 1 | Move-up pulse |
| btn_dn | input | 1 | Move-down pulse |
| btn_lt | input | 1 | Move-left pulse |
| btn_rt | input | 1 | Move-right pulse |
| btn_home | input | 1 | Return-home pulse, also counted |
| rgb | output | 12 | Pixel colour, 4 bits per channel, red in the top nibble |
| anchor_x | output | 10 | Registered column of the rectangle's top-left corner |
| anchor_y | output | 10 | Registered row of the rectangle's top-left corner |
| reset_count | output | 16 | Four BCD digits counting home pulses |

## Verification
The bench probes pixels that lie exactly on the disc radius, and the neighbours one step outside. A comparison written with < in place of <=, or a centre offset set wrong, therefore changes a pixel from yellow to black or the reverse. It also probes the rectangle's last column and row, and points in the overlap. An off-by-one in the rectangle extent, or the wrong colour priority, shows up there as blue in place of black or yellow. The anchor is driven into all four clamp limits over many frames. A pulse is made to coincide with the strobe, and opposite pulses are given in one frame. A design that moved without waiting for the strobe, stepped once per pulse, or overshot a limit would read back a wrong anchor. The tally is run through 9999, where a broken digit carry would show a value other than 0000.

// File: rtl/shape_pkg.sv
package shape_pkg;

  typedef logic [11:0] rgb_t;

  localparam rgb_t COL_BLACK  = 12'h000;
  localparam rgb_t COL_YELLOW = 12'hFF0;
  localparam rgb_t COL_BLUE   = 12'h00F;

  // bit positions in the pending-move vector
  localparam int MV_UP   = 0;
  localparam int MV_DN   = 1;
  localparam int MV_LT   = 2;
  localparam int MV_RT   = 3;
  localparam int MV_HOME = 4;
  localparam int MV_N    = 5;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pos_ctrl.sv
module pos_ctrl
  import shape_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int STEP    = 4,
  parameter int X_MIN   = 10,
  parameter int X_MAX   = 560,
  parameter int Y_MIN   = 15,
  parameter int Y_MAX   = 414,
  parameter int HOME_X  = 280,
  parameter int HOME_Y  = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [MV_N-1:0]    mv_req,
  output logic [COORD_W-1:0] ax,
  output logic [COORD_W-1:0] ay
);

  localparam int SW = COORD_W + 2;
  localparam logic signed [SW-1:0] S_STEP  = SW'(STEP);
  localparam logic signed [SW-1:0] S_X_MIN = SW'(X_MIN);
  localparam logic signed [SW-1:0] S_X_MAX = SW'(X_MAX);
  localparam logic signed [SW-1:0] S_Y_MIN = SW'(Y_MIN);
  localparam logic signed [SW-1:0] S_Y_MAX = SW'(Y_MAX);

  logic [MV_N-1:0]    pend_q, pend_d, req_all;
  logic [COORD_W-1:0] ax_q, ax_d, ay_q, ay_d;
  logic               pos_en;
  logic signed [SW-1:0] x_try, y_try;

  function automatic logic [COORD_W-1:0] clamp_c(
    input logic signed [SW-1:0] v,
    input logic signed [SW-1:0] lo,
    input logic signed [SW-1:0] hi);
    logic signed [SW-1:0] r;
    if (v < lo)      r = lo;
    else if (v > hi) r = hi;
    else             r = v;
    return r[COORD_W-1:0];
  endfunction

  assign req_all = pend_q | mv_req;
  assign pos_en  = frame_end;

  always_comb begin
    x_try = $signed({2'b00, ax_q});
    y_try = $signed({2'b00, ay_q});
    if (req_all[MV_RT]) x_try = x_try + S_STEP;
    if (req_all[MV_LT]) x_try = x_try - S_STEP;
    if (req_all[MV_DN]) y_try = y_try + S_STEP;
    if (req_all[MV_UP]) y_try = y_try - S_STEP;
  end

  always_comb begin
    if (frame_end) pend_d = '0;
    else           pend_d = req_all;
    if (req_all[MV_HOME]) begin
      ax_d = COORD_W'(HOME_X);
      ay_d = COORD_W'(HOME_Y);
    end else begin
      ax_d = clamp_c(x_try, S_X_MIN, S_X_MAX);
      ay_d = clamp_c(y_try, S_Y_MIN, S_Y_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ax_q <= COORD_W'(HOME_X);
      ay_q <= COORD_W'(HOME_Y);
    end else if (pos_en) begin
      ax_q <= ax_d;
      ay_q <= ay_d;
    end
  end

  assign ax = ax_q;
  assign ay = ay_q;

  AST_X_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ax_q >= COORD_W'(X_MIN)) && (ax_q <= COORD_W'(X_MAX))); // R4
  AST_Y_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ay_q >= COORD_W'(Y_MIN)) && (ay_q <= COORD_W'(Y_MAX))); // R4
  AST_HOLD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(ax_q) && $stable(ay_q))); // R3
  AST_HOME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (pend_q[MV_HOME] || mv_req[MV_HOME]))
      |=> (ax_q == COORD_W'(HOME_X)) && (ay_q == COORD_W'(HOME_Y))); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pend_q == '0)); // R3

endmodule

// File: rtl/shape_hit.sv
module shape_hit #(
  parameter int COORD_W = 10,
  parameter int RECT_W  = 80,
  parameter int RECT_H  = 50,
  parameter int CIRC_R  = 40,
  parameter int OFS_X   = 30,
  parameter int OFS_Y   = 25
) (
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  input  logic [COORD_W-1:0] ax,
  input  logic [COORD_W-1:0] ay,
  output logic               in_circle,
  output logic               in_rect
);

  localparam int EW = COORD_W + 1;
  localparam int QW = 2 * EW + 1;
  localparam logic [QW-1:0] R_SQ = QW'(CIRC_R * CIRC_R);

  logic [EW-1:0] px_e, py_e, ax_e, ay_e, cx, cy, dx, dy;
  logic [QW-1:0] dist_sq;

  assign px_e = {1'b0, px};
  assign py_e = {1'b0, py};
  assign ax_e = {1'b0, ax};
  assign ay_e = {1'b0, ay};
  assign cx   = ax_e + EW'(OFS_X);
  assign cy   = ay_e + EW'(OFS_Y);
  assign dx   = (px_e >= cx) ? (px_e - cx) : (cx - px_e);
  assign dy   = (py_e >= cy) ? (py_e - cy) : (cy - py_e);
  assign dist_sq = QW'(dx * dx) + QW'(dy * dy);

  assign in_circle = (dist_sq <= R_SQ);
  assign in_rect   = (px_e >= ax_e) && (px_e < ax_e + EW'(RECT_W)) &&
                     (py_e >= ay_e) && (py_e < ay_e + EW'(RECT_H));

endmodule

// File: rtl/bcd_tally.sv
module bcd_tally #(
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [4*DIGITS-1:0] count
);

  logic [DIGITS:0] carry;
  assign carry[0] = inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig_q, dig_d;
    logic       dig_en;

    assign dig_en       = carry[g];
    assign carry[g + 1] = carry[g] && (dig_q == 4'd9);
    assign dig_d        = (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dig_q <= 4'd0;
      else if (dig_en) dig_q <= dig_d;
    end

    assign count[4*g +: 4] = dig_q;

    AST_BCD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      dig_q <= 4'd9); // R7
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R6

endmodule

// File: rtl/shape_renderer.sv
module shape_renderer
  import shape_pkg::*;
#(
  parameter int COORD_W = 10,
  parameter int H_RES   = 640,
  parameter int V_RES   = 480,
  parameter int RECT_W  = 80,
  parameter int RECT_H  = 50,
  parameter int CIRC_R  = 40,
  parameter int OFS_X   = 30,
  parameter int OFS_Y   = 25,
  parameter int STEP    = 4,
  parameter int HOME_X  = 280,
  parameter int HOME_Y  = 200,
  parameter int DIGITS  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               vid_on,
  input  logic               frame_end,
  input  logic               btn_up,
  input  logic               btn_dn,
  input  logic               btn_lt,
  input  logic               btn_rt,
  input  logic               btn_home,
  output logic [11:0]        rgb,
  output logic [COORD_W-1:0] anchor_x,
  output logic [COORD_W-1:0] anchor_y,
  output logic [4*DIGITS-1:0] reset_count
);

  // extents of the object measured from the anchor
  localparam int LEFT_EXT  = imax(0, CIRC_R - OFS_X);
  localparam int TOP_EXT   = imax(0, CIRC_R - OFS_Y);
  localparam int RIGHT_EXT = imax(RECT_W - 1, OFS_X + CIRC_R);
  localparam int BOT_EXT   = imax(RECT_H - 1, OFS_Y + CIRC_R);
  localparam int X_MIN     = LEFT_EXT;
  localparam int X_MAX     = H_RES - 1 - RIGHT_EXT;
  localparam int Y_MIN     = TOP_EXT;
  localparam int Y_MAX     = V_RES - 1 - BOT_EXT;

  logic            rst_n_s;
  logic [MV_N-1:0] mv_req;
  logic            in_circle, in_rect;
  rgb_t            rgb_d, rgb_q;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    mv_req          = '0;
    mv_req[MV_UP]   = btn_up;
    mv_req[MV_DN]   = btn_dn;
    mv_req[MV_LT]   = btn_lt;
    mv_req[MV_RT]   = btn_rt;
    mv_req[MV_HOME] = btn_home;
  end

  pos_ctrl #(
    .COORD_W (COORD_W), .STEP (STEP),
    .X_MIN (X_MIN), .X_MAX (X_MAX), .Y_MIN (Y_MIN), .Y_MAX (Y_MAX),
    .HOME_X (HOME_X), .HOME_Y (HOME_Y)
  ) u_pos (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .frame_end (frame_end),
    .mv_req    (mv_req),
    .ax        (anchor_x),
    .ay        (anchor_y)
  );

  shape_hit #(
    .COORD_W (COORD_W), .RECT_W (RECT_W), .RECT_H (RECT_H),
    .CIRC_R (CIRC_R), .OFS_X (OFS_X), .OFS_Y (OFS_Y)
  ) u_hit (
    .px        (pix_x),
    .py        (pix_y),
    .ax        (anchor_x),
    .ay        (anchor_y),
    .in_circle (in_circle),
    .in_rect   (in_rect)
  );

  bcd_tally #(.DIGITS (DIGITS)) u_tally (
    .clk   (clk),
    .rst_n (rst_n_s),
    .inc   (btn_home),
    .count (reset_count)
  );

  // colour priority: disc over rectangle over background
  always_comb begin
    if (!vid_on)        rgb_d = COL_BLACK;
    else if (in_circle) rgb_d = COL_YELLOW;
    else if (in_rect)   rgb_d = COL_BLUE;
    else                rgb_d = COL_BLACK;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rgb_q <= COL_BLACK;
    else          rgb_q <= rgb_d;
  end

  assign rgb = rgb_q;

  AST_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n_s)
    !vid_on |=> (rgb_q == COL_BLACK)); // R10
  AST_DISC_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vid_on && in_circle) |=> (rgb_q == COL_YELLOW)); // R8
  AST_RECT_ONLY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (vid_on && in_rect && !in_circle) |=> (rgb_q == COL_BLUE)); // R9
  AST_COLOUR_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rgb_q == COL_BLACK) || (rgb_q == COL_YELLOW) || (rgb_q == COL_BLUE)); // R9

endmodule

// File: tb/sim_shape_renderer.sv
`timescale 1ns/1ps
module sim_shape_renderer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  pix_x, pix_y;
  logic        vid_on, frame_end;
  logic [4:0]  btn;   // 0 up, 1 down, 2 left, 3 right, 4 home
  logic [11:0] rgb;
  logic [9:0]  anchor_x, anchor_y;
  logic [15:0] reset_count;

  int total = 0;
  int bad   = 0;
  int homes = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  shape_renderer u0 (
    .clk (clk), .rst_n (rst_n),
    .pix_x (pix_x), .pix_y (pix_y), .vid_on (vid_on), .frame_end (frame_end),
    .btn_up (btn[0]), .btn_dn (btn[1]), .btn_lt (btn[2]), .btn_rt (btn[3]),
    .btn_home (btn[4]),
    .rgb (rgb), .anchor_x (anchor_x), .anchor_y (anchor_y),
    .reset_count (reset_count)
  );

  // {x, y, vid, expected colour} with the anchor at home (280,200)
  localparam logic [32:0] VEC [16] = '{
    {10'd310, 10'd225, 1'b1, 12'hFF0},  // R8 centre, inside both (R9 priority)
    {10'd350, 10'd225, 1'b1, 12'hFF0},  // R8 right radius exactly
    {10'd351, 10'd225, 1'b1, 12'h00F},  // R9 just past the disc, in rect
    {10'd359, 10'd200, 1'b1, 12'h00F},  // R9 top-right corner of rect
    {10'd360, 10'd200, 1'b1, 12'h000},  // R10 one column past rect
    {10'd359, 10'd249, 1'b1, 12'h00F},  // R9 bottom-right corner of rect
    {10'd359, 10'd250, 1'b1, 12'h000},  // R10 one row past rect
    {10'd310, 10'd185, 1'b1, 12'hFF0},  // R8 top of disc
    {10'd310, 10'd184, 1'b1, 12'h000},  // R10 above disc
    {10'd270, 10'd225, 1'b1, 12'hFF0},  // R8 left of disc, outside rect
    {10'd269, 10'd225, 1'b1, 12'h000},  // R10 just left of disc
    {10'd338, 10'd253, 1'b1, 12'hFF0},  // R8 diagonal, 1568 <= 1600
    {10'd339, 10'd253, 1'b1, 12'h000},  // R10 diagonal, 1625 > 1600
    {10'd310, 10'd225, 1'b0, 12'h000},  // R10 blanked in disc
    {10'd300, 10'd240, 1'b0, 12'h000},  // R10 blanked in overlap
    {10'd0,   10'd0,   1'b1, 12'h000}   // R10 far background
  };

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input int x, input int y, input bit v,
                       input logic [11:0] exp);
    @(negedge clk);
    pix_x = 10'(x); pix_y = 10'(y); vid_on = v;
    @(negedge clk);
    check(req, 32'(rgb), 32'(exp));
  endtask

  task automatic press(input int idx);
    @(negedge clk); btn[idx] = 1'b1;
    @(negedge clk); btn[idx] = 1'b0;
    if (idx == 4) homes++;
  endtask

  task automatic strobe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic move_frames(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      press(idx);
      strobe();
    end
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_x = '0; pix_y = '0; vid_on = 1'b0;
    frame_end = 1'b0; btn = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 anchor_x", 32'(anchor_x), 32'd280);
    check("R1 anchor_y", 32'(anchor_y), 32'd200);
    check("R1 count", 32'(reset_count), 32'h0);
    check("R1 rgb", 32'(rgb), 32'h0);

    // pixel table at home anchor
    for (int i = 0; i < 16; i++)
      probe("R8/R9/R10 table", int'(VEC[i][32:23]), int'(VEC[i][22:13]),
            VEC[i][12], VEC[i][11:0]);

    // R3 held until strobe, R2 applied on strobe
    press(3);
    repeat (3) @(negedge clk);
    check("R3 no move before strobe", 32'(anchor_x), 32'd280);
    strobe();
    check("R2 right step", 32'(anchor_x), 32'd284);

    // R3 repeated pulses give one step
    press(0); press(0);
    strobe();
    check("R3 one step for two ups", 32'(anchor_y), 32'd196);

    // R3 opposite pulses cancel
    press(2); press(3);
    strobe();
    check("R3 left+right cancel", 32'(anchor_x), 32'd284);

    // R2 pulse coinciding with strobe
    @(negedge clk); btn[1] = 1'b1; frame_end = 1'b1;
    @(negedge clk); btn[1] = 1'b0; frame_end = 1'b0;
    check("R2 coincident down", 32'(anchor_y), 32'd200);

    // R6 count, R5 home overrides pending move
    press(4);
    check("R6 count after home", 32'(reset_count), 32'(to_bcd(homes)));
    press(3);
    check("R3 home waits for strobe", 32'(anchor_x), 32'd284);
    strobe();
    check("R5 home x", 32'(anchor_x), 32'd280);
    check("R5 home y", 32'(anchor_y), 32'd200);

    // R4 clamps
    move_frames(2, 80);
    check("R4 left limit", 32'(anchor_x), 32'd10);
    move_frames(0, 60);
    check("R4 top limit", 32'(anchor_y), 32'd15);
    probe("R8 disc at left screen edge", 0, 40, 1'b1, 12'hFF0);
    move_frames(3, 150);
    check("R4 right limit", 32'(anchor_x), 32'd560);
    move_frames(1, 120);
    check("R4 bottom limit", 32'(anchor_y), 32'd414);
    probe("R8 disc at right edge", 630, 439, 1'b1, 12'hFF0);
    probe("R9 rect at bottom-right", 639, 463, 1'b1, 12'h00F);
    probe("R10 below rect corner", 639, 464, 1'b1, 12'h000);

    // R5 home from the corner, R7 not cleared by home
    press(4);
    check("R7 home does not clear tally", 32'(reset_count), 32'h0002);
    strobe();
    check("R5 home from corner x", 32'(anchor_x), 32'd280);
    check("R5 home from corner y", 32'(anchor_y), 32'd200);

    // R7 wrap
    while (homes < 9999) press(4);
    check("R6 count 9999", 32'(reset_count), 32'h9999);
    press(4);
    check("R7 wrap to 0000", 32'(reset_count), 32'h0000);
    press(4);
    check("R6 count after wrap", 32'(reset_count), 32'h0001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule